// File: doc/BRIEF.md
# Address-Filtering Asynchronous Serial Receiver

This block receives asynchronous serial frames in which an optional extra bit, placed after the data byte, marks the frame as an address (bit set) or as data (bit clear). Software on a node that shares a line with several others arms a filter. While the filter is armed, the receiver drops every data frame without delivering it and without raising an error. The first address frame that arrives disarms the filter and is delivered like any other frame, so the node sees only traffic that follows its own address.

The receiver works from an oversampling tick. Each bit lasts 16 ticks, or 8 ticks when the double-speed select is set. Each bit is sampled once, at its middle. Received bytes appear on a data output together with a one-cycle valid strobe. Sticky overrun and framing flags report lost or malformed frames that the filter did not suppress.

Top module: `mpx_rx_filter`

## Requirements
- R1: A frame is a low start bit, 8 data bits with the least significant bit first, then the address bit when `mp_mode` is 1, then one stop bit. Counting the tick that first sees the line low in idle as tick 0, bit k is sampled at tick k*N + N/2, where N is the ticks per bit.
- R2: If the line is high again when the start bit is sampled at its middle, the receiver treats the low as noise, returns to idle and produces no frame.
- R3: With the filter inactive, every completed frame is delivered. `rx_valid` is high for exactly one cycle, the cycle after the clock edge that samples the stop bit. In that cycle `rx_data` holds the byte and `rx_mpb` holds the address bit (1 when `mp_mode` is 0).
- R4: If the filter was armed when the start bit was validated and the address bit is 0, the frame is not delivered, `rx_data` keeps its old value, and neither `ovr_err` nor `frm_err` changes, even when the stop bit is low or earlier data is unread.
- R5: If the filter was armed when the start bit was validated and the address bit is 1, the frame is delivered as in R3 and `arm_state` falls to 0 in the same cycle.
- R6: With `mp_mode` at 0 there is no address bit and the filter has no effect: every frame is delivered and `arm_state` keeps its value.
- R7: A delivered frame whose stop bit samples low sets `frm_err`. The byte is still delivered.
- R8: A frame that completes while the previous byte is unread sets `ovr_err`. That frame is discarded and `rx_data` keeps the old byte. A `data_rd` pulse at the edge where the frame completes counts as a read, and the new frame is then delivered.
- R9: `ovr_err` and `frm_err` stay set until `err_clr` is pulsed.
- R10: `arm_wr` loads `arm_wdata` into `arm_state` at the next edge, and a write takes priority over an automatic clear at the same edge. A change of `arm_state` takes effect only from the next start bit that is validated.
- R11: While `rx_en` is 0 the receiver stays idle or abandons a frame in progress, and no frame is delivered.
- R12: With `dbl_speed` at 1, each bit lasts 8 ticks and is sampled at tick 4 within the bit.
- R13: After reset, `rx_valid`, `rx_data`, `rx_mpb`, `ovr_err`, `frm_err` and `arm_state` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receive enable |
| rxd | input | 1 | Serial line, idle high |
| os_tick | input | 1 | Oversampling tick, one cycle per tick |
| mp_mode | input | 1 | Frames carry an address bit |
| dbl_speed | input | 1 | 8 ticks per bit instead of 16 |
| arm_wr | input | 1 | Write strobe for the arm bit |
| arm_wdata | input | 1 | Value written to the arm bit |
| data_rd | input | 1 | Software has read the received byte |
| err_clr | input | 1 | Clears both error flags |
| rx_valid | output | 1 | One-cycle strobe for a delivered byte |
| rx_data | output | 8 | Last delivered byte |
| rx_mpb | output | 1 | Address bit of the last delivered byte |
| ovr_err | output | 1 | Sticky overrun flag |
| frm_err | output | 1 | Sticky framing flag |
| arm_state | output | 1 | Current arm bit |

## Verification
The main function is tried with four kinds of frame while the filter is armed: data frames with a clean stop bit, data frames with a low stop bit and an unread byte pending, address frames, and an arm write that lands in the middle of a frame. Comparing these shows that suppression hides both the byte and both flags, that an address frame both disarms the filter and is delivered, and that the arm bit is latched only at start validation. The same byte patterns are also sent with the filter disarmed, with the address format off, and at double speed. This separates the filtering behaviour from framing, overrun and timing behaviour. Noise pulses and a receive enable dropped part way through a frame show that an incomplete frame never produces a strobe.

// File: rtl/mpx_rx_pkg.sv
// Shared definitions for the address-filtering serial receiver.
// Assumes a byte-wide data field.
package mpx_rx_pkg;

    parameter int unsigned DW = 8;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_BUSY = 1'b1
    } rx_state_e;

    // Fields of a completed frame, handed from the framer to the flag logic.
    typedef struct packed {
        logic [DW-1:0] data;
        logic          mpb;
        logic          stop_ok;
        logic          filt;
    } rx_frame_t;

endpackage

// File: rtl/mpx_rx_timer.sv
// Mid-bit sample timer. Loaded when a start edge is seen, it fires a
// sample strobe N/2 ticks later and then every N ticks.
// Assumes OS_NORM >= OS_FAST and that both are even.
module mpx_rx_timer #(
    parameter int unsigned OS_NORM = 16,
    parameter int unsigned OS_FAST = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic os_tick,
    input  logic load,
    input  logic run,
    input  logic fast,
    output logic smp
);
    localparam int unsigned PH_W = $clog2(OS_NORM);
    localparam logic [PH_W-1:0] HALF_N = PH_W'(OS_NORM / 2 - 1);
    localparam logic [PH_W-1:0] HALF_F = PH_W'(OS_FAST / 2 - 1);
    localparam logic [PH_W-1:0] FULL_N = PH_W'(OS_NORM - 1);
    localparam logic [PH_W-1:0] FULL_F = PH_W'(OS_FAST - 1);

    logic [PH_W-1:0] ph;
    logic            fast_q;

    assign smp = run && os_tick && (ph == '0);

    // Count ticks down to the next sample point and reload after each one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph     <= '0;
            fast_q <= 1'b0;
        end else if (load) begin
            fast_q <= fast;
            ph     <= fast ? HALF_F : HALF_N;
        end else if (run && os_tick) begin
            if (ph == '0) begin
                ph <= fast_q ? FULL_F : FULL_N;
            end else begin
                ph <= ph - 1'b1;
            end
        end
    end

endmodule

// File: rtl/mpx_rx_framer.sv
// Frame assembler. It detects the start edge, validates the start bit,
// shifts in the data bits with the least significant bit first, captures the
// address bit and flags completion on the stop sample. The arm bit and the
// format are latched once per frame.
module mpx_rx_framer
    import mpx_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rx_en,
    input  logic      rxd,
    input  logic      os_tick,
    input  logic      mp_mode,
    input  logic      arm,
    input  logic      smp,
    output logic      load,
    output logic      run,
    output logic      fin,
    output rx_frame_t frame
);
    localparam int unsigned IDX_W = $clog2(DW + 3);
    localparam logic [IDX_W-1:0] LAST_MP = IDX_W'(DW + 2);
    localparam logic [IDX_W-1:0] LAST_PL = IDX_W'(DW + 1);
    localparam logic [IDX_W-1:0] DATA_HI = IDX_W'(DW);

    rx_state_e        state;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] last;
    logic [DW-1:0]    shreg;
    logic             mpb_q;
    logic             mpm_q;
    logic             filt_q;

    assign last = mpm_q ? LAST_MP : LAST_PL;
    assign load = (state == RX_IDLE) && rx_en && os_tick && !rxd;
    assign run  = (state == RX_BUSY);
    assign fin  = run && rx_en && smp && (idx == last);

    assign frame.data    = shreg;
    assign frame.mpb     = mpb_q;
    assign frame.stop_ok = rxd;
    assign frame.filt    = filt_q;

    // Step through the bit positions of one frame at each sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= RX_IDLE;
            idx    <= '0;
            shreg  <= '0;
            mpb_q  <= 1'b1;
            mpm_q  <= 1'b0;
            filt_q <= 1'b0;
        end else if (!rx_en) begin
            state <= RX_IDLE;
        end else if (load) begin
            state <= RX_BUSY;
            idx   <= '0;
            mpm_q <= mp_mode;
            mpb_q <= 1'b1;
        end else if (run && smp) begin
            if (idx == '0) begin
                if (rxd) begin
                    state <= RX_IDLE;
                end else begin
                    filt_q <= arm && mpm_q;
                    idx    <= idx + 1'b1;
                end
            end else if (idx == last) begin
                state <= RX_IDLE;
            end else if (idx <= DATA_HI) begin
                shreg <= {rxd, shreg[DW-1:1]};
                idx   <= idx + 1'b1;
            end else begin
                mpb_q <= rxd;
                idx   <= idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/mpx_rx_flags.sv
// Delivery and flag logic. It applies the filter to a completed frame,
// holds the output byte, tracks whether the byte was read, and keeps the
// sticky error flags and the arm bit.
module mpx_rx_flags
    import mpx_rx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fin,
    input  rx_frame_t     frame,
    input  logic          data_rd,
    input  logic          err_clr,
    input  logic          arm_wr,
    input  logic          arm_wdata,
    output logic          rx_valid,
    output logic [DW-1:0] rx_data,
    output logic          rx_mpb,
    output logic          ovr_err,
    output logic          frm_err,
    output logic          arm_q
);
    logic full;
    logic supp;
    logic pending;
    logic take;
    logic ovr_set;
    logic fe_set;
    logic wake;

    // Classify the completed frame.
    always_comb begin
        supp    = frame.filt && !frame.mpb;
        pending = full && !data_rd;
        take    = fin && !supp && !pending;
        ovr_set = fin && !supp && pending;
        fe_set  = take && !frame.stop_ok;
        wake    = fin && frame.filt && frame.mpb;
    end

    // Hold the delivered byte and track whether it is still unread.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_data  <= '0;
            rx_mpb   <= 1'b0;
            full     <= 1'b0;
        end else begin
            rx_valid <= take;
            full     <= take || pending;
            if (take) begin
                rx_data <= frame.data;
                rx_mpb  <= frame.mpb;
            end
        end
    end

    // Keep the sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_err <= 1'b0;
            frm_err <= 1'b0;
        end else begin
            ovr_err <= ovr_set || (ovr_err && !err_clr);
            frm_err <= fe_set || (frm_err && !err_clr);
        end
    end

    // Update the arm bit. A software write takes priority over the clear by an address frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q <= 1'b0;
        end else if (arm_wr) begin
            arm_q <= arm_wdata;
        end else if (wake) begin
            arm_q <= 1'b0;
        end
    end

endmodule

// File: rtl/mpx_rx_filter.sv
// Top level of the address-filtering asynchronous receiver. It wires the
// sample timer, the framer and the delivery and flag logic together.
// Assumes os_tick is a one-cycle pulse and the mode inputs are steady
// while a frame is in progress.
module mpx_rx_filter
    import mpx_rx_pkg::*;
#(
    parameter int unsigned OS_NORM = 16,
    parameter int unsigned OS_FAST = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic          rxd,
    input  logic          os_tick,
    input  logic          mp_mode,
    input  logic          dbl_speed,
    input  logic          arm_wr,
    input  logic          arm_wdata,
    input  logic          data_rd,
    input  logic          err_clr,
    output logic          rx_valid,
    output logic [DW-1:0] rx_data,
    output logic          rx_mpb,
    output logic          ovr_err,
    output logic          frm_err,
    output logic          arm_state
);
    logic      load;
    logic      run;
    logic      smp;
    logic      fin;
    rx_frame_t frame;

    mpx_rx_timer #(
        .OS_NORM(OS_NORM),
        .OS_FAST(OS_FAST)
    ) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .os_tick(os_tick),
        .load   (load),
        .run    (run),
        .fast   (dbl_speed),
        .smp    (smp)
    );

    mpx_rx_framer framer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_en  (rx_en),
        .rxd    (rxd),
        .os_tick(os_tick),
        .mp_mode(mp_mode),
        .arm    (arm_state),
        .smp    (smp),
        .load   (load),
        .run    (run),
        .fin    (fin),
        .frame  (frame)
    );

    mpx_rx_flags flags_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fin      (fin),
        .frame    (frame),
        .data_rd  (data_rd),
        .err_clr  (err_clr),
        .arm_wr   (arm_wr),
        .arm_wdata(arm_wdata),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_mpb   (rx_mpb),
        .ovr_err  (ovr_err),
        .frm_err  (frm_err),
        .arm_q    (arm_state)
    );

endmodule

// File: rtl/mpx_rx_filter_chk.sv
// Port-level properties of the address-filtering receiver, attached to
// the top module by bind.
module mpx_rx_filter_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_en,
    input logic arm_wr,
    input logic arm_wdata,
    input logic err_clr,
    input logic rx_valid,
    input logic rx_mpb,
    input logic ovr_err,
    input logic frm_err,
    input logic arm_state
);
    // R3
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R5
    wake_delivers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(arm_state) && !$past(arm_wr)) |-> (rx_valid && rx_mpb));

    // R8
    ovr_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_err) |-> !rx_valid);

    // R9
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_err && !err_clr) |=> ovr_err);

    // R9
    frm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_err && !err_clr) |=> frm_err);

    // R11
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !rx_valid);

    // R10
    arm_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm_wr |=> (arm_state == $past(arm_wdata)));

endmodule

bind mpx_rx_filter mpx_rx_filter_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .arm_wr   (arm_wr),
    .arm_wdata(arm_wdata),
    .err_clr  (err_clr),
    .rx_valid (rx_valid),
    .rx_mpb   (rx_mpb),
    .ovr_err  (ovr_err),
    .frm_err  (frm_err),
    .arm_state(arm_state)
);

// File: tb/mpx_rx_filter_tb_top.sv
`timescale 1ns/1ps
// Bench for the address-filtering receiver. It keeps a behavioural model of
// the outputs and compares against it after every clock edge.
module mpx_rx_filter_tb_top;

    localparam int GAP = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en = 1'b0;
    logic rxd = 1'b1;
    logic os_tick = 1'b0;
    logic mp_mode = 1'b0;
    logic dbl_speed = 1'b0;
    logic arm_wr = 1'b0;
    logic arm_wdata = 1'b0;
    logic data_rd = 1'b0;
    logic err_clr = 1'b0;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_mpb;
    logic       ovr_err;
    logic       frm_err;
    logic       arm_state;

    always #2 clk = ~clk;

    mpx_rx_filter dut_i (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rxd(rxd), .os_tick(os_tick),
        .mp_mode(mp_mode), .dbl_speed(dbl_speed), .arm_wr(arm_wr),
        .arm_wdata(arm_wdata), .data_rd(data_rd), .err_clr(err_clr),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_mpb(rx_mpb),
        .ovr_err(ovr_err), .frm_err(frm_err), .arm_state(arm_state)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R13";
    bit    done = 1'b0;

    // reference state
    bit       m_valid, m_mpb, m_ovr, m_frm, m_arm, m_full;
    bit [7:0] m_data;
    // frame completing at the next edge, if p_fin is set
    bit       p_fin, p_mpb, p_stop, p_filt;
    bit [7:0] p_data;

    task automatic chk(string name, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, name, act, exp);
        end
    endtask

    // One clock: update the model with the inputs seen at the edge, then compare.
    task automatic step();
        bit set_ovr, set_frm, new_full;
        @(posedge clk);
        #1;
        if (!rst_n) begin
            m_valid = 0; m_data = 0; m_mpb = 0; m_ovr = 0; m_frm = 0;
            m_arm = 0; m_full = 0; p_fin = 0;
        end else begin
            set_ovr = 0; set_frm = 0;
            m_valid = 0;
            new_full = m_full && !data_rd;
            if (p_fin) begin
                if (!(p_filt && !p_mpb)) begin
                    if (m_full && !data_rd) begin
                        set_ovr = 1;
                    end else begin
                        m_valid = 1; m_data = p_data; m_mpb = p_mpb;
                        new_full = 1;
                        if (!p_stop) set_frm = 1;
                    end
                end
                if (p_filt && p_mpb) m_arm = 0;
            end
            if (arm_wr) m_arm = arm_wdata;
            m_ovr = set_ovr || (m_ovr && !err_clr);
            m_frm = set_frm || (m_frm && !err_clr);
            m_full = new_full;
            p_fin = 0;
        end
        chk("rx_valid", rx_valid, m_valid);
        chk("rx_data", rx_data, m_data);
        chk("rx_mpb", rx_mpb, m_mpb);
        chk("ovr_err", ovr_err, m_ovr);
        chk("frm_err", frm_err, m_frm);
        chk("arm_state", arm_state, m_arm);
    endtask

    // One oversampling tick followed by its idle cycles.
    task automatic tick(bit v, bit fin_here);
        rxd = v;
        os_tick = 1;
        if (fin_here) p_fin = 1;
        step();
        os_tick = 0;
        arm_wr = 0; data_rd = 0; err_clr = 0;
        repeat (GAP - 1) step();
    endtask

    task automatic idle(int n);
        repeat (n) tick(1'b1, 1'b0);
    endtask

    task automatic read_data();
        data_rd = 1; step(); data_rd = 0;
    endtask

    task automatic clear_err();
        err_clr = 1; step(); err_clr = 0;
    endtask

    task automatic write_arm(bit v);
        arm_wr = 1; arm_wdata = v; step(); arm_wr = 0;
    endtask

    // Send one frame. At bit ev_bit, tick ev_j, fire a one-shot event
    // (ev_sel 0: write 1 to the arm bit, 1: read the data); en_off drops rx_en.
    task automatic send_frame(bit [7:0] d, bit mpb, bit stop, bit completes,
                              int ev_bit = -1, int ev_j = 0, int ev_sel = 0,
                              int en_off = -1);
        int n;
        int nb;
        bit v;
        n  = dbl_speed ? 8 : 16;
        nb = mp_mode ? 11 : 10;
        p_data = d; p_mpb = mp_mode ? mpb : 1'b1; p_stop = stop;
        p_filt = m_arm && mp_mode;
        for (int k = 0; k < nb; k++) begin
            if (k == 0) v = 0;
            else if (k <= 8) v = d[k-1];
            else if (mp_mode && k == 9) v = mpb;
            else v = stop;
            for (int j = 0; j < n; j++) begin
                if (k == en_off && j == 0) rx_en = 0;
                if (k == ev_bit && j == ev_j) begin
                    if (ev_sel == 0) begin arm_wr = 1; arm_wdata = 1; end
                    else data_rd = 1;
                end
                tick(v, completes && k == nb - 1 && j == n / 2);
            end
        end
        idle(12);
    endtask

    initial begin
        cur_req = "R13";
        repeat (3) step();
        rst_n = 1;
        step();
        mp_mode = 1; rx_en = 1;
        idle(12);

        // plain reception with the filter off
        cur_req = "R1";
        send_frame(8'hA5, 1'b0, 1'b1, 1'b1);
        read_data();
        cur_req = "R3";
        send_frame(8'h3C, 1'b1, 1'b1, 1'b1);
        read_data();

        // double speed
        cur_req = "R12";
        dbl_speed = 1;
        send_frame(8'h81, 1'b0, 1'b1, 1'b1);
        read_data();
        dbl_speed = 0;

        // noise on the line, high again at mid start bit
        cur_req = "R2";
        repeat (3) tick(1'b0, 1'b0);
        idle(30);

        // armed filter drops data frames without raising flags
        cur_req = "R4";
        send_frame(8'h22, 1'b0, 1'b1, 1'b1);
        write_arm(1);
        send_frame(8'h44, 1'b0, 1'b0, 1'b1);
        send_frame(8'h45, 1'b0, 1'b1, 1'b1);
        read_data();

        // an address frame wakes the node and is delivered
        cur_req = "R5";
        send_frame(8'h9E, 1'b1, 1'b1, 1'b1);
        read_data();

        // an arm write in mid-frame applies to the next frame only
        cur_req = "R10";
        send_frame(8'h66, 1'b0, 1'b1, 1'b1, 4, 1, 0);
        read_data();
        send_frame(8'h77, 1'b0, 1'b1, 1'b1);
        // a write at the completing edge takes priority over the automatic clear
        send_frame(8'hC3, 1'b1, 1'b1, 1'b1, 10, 8, 0);
        read_data();
        write_arm(0);

        // without the address bit the filter has no effect
        cur_req = "R6";
        mp_mode = 0;
        write_arm(1);
        send_frame(8'h5A, 1'b0, 1'b1, 1'b1);
        read_data();
        write_arm(0);
        mp_mode = 1;

        // low stop bit
        cur_req = "R7";
        send_frame(8'h0F, 1'b0, 1'b0, 1'b1);
        read_data();
        cur_req = "R9";
        idle(4);
        clear_err();

        // overrun
        cur_req = "R8";
        send_frame(8'hF0, 1'b0, 1'b1, 1'b1);
        send_frame(8'h12, 1'b1, 1'b1, 1'b1);
        read_data();
        send_frame(8'h34, 1'b0, 1'b1, 1'b1);
        send_frame(8'h35, 1'b0, 1'b1, 1'b1, 10, 8, 1);
        read_data();
        cur_req = "R9";
        idle(4);
        clear_err();

        // receive enable off, then dropped in mid-frame
        cur_req = "R11";
        rx_en = 0;
        send_frame(8'h00, 1'b0, 1'b1, 1'b0);
        rx_en = 1;
        idle(12);
        send_frame(8'h00, 1'b0, 1'b1, 1'b0, -1, 0, 0, 3);
        rx_en = 1;
        idle(12);
        send_frame(8'hBD, 1'b0, 1'b1, 1'b1);
        read_data();
        idle(4);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule